// File: doc/BRIEF.md
# Command Packet Receiver and Validator

This block sits behind a byte-wide host link, such as the data/valid output of a UART receiver. It turns the incoming byte stream into command packets. A packet opens with a four-byte header: a start marker, an opcode, and a two-byte payload count. The payload bytes follow the header. The receiver hunts for the start marker and checks the header. It then compares the declared payload count with the count that the opcode demands. Payload bytes of accepted packets go into a small on-chip buffer.

When a packet is good, the block presents a command strobe together with the opcode, the payload count and a synchronous read port into the buffer. All of these hold until the executing logic answers with a ready. When a packet is malformed, it is thrown away. A one-cycle status pulse then tells the response logic to send either a negative acknowledge (0x02) or a not-implemented answer (0xFF). A programmable inter-byte gap limit abandons packets whose sender stalled part way through.

Top module: `cmd_pkt_rx`

## Requirements
- R1: While hunting, any byte other than 0xAA has no effect. A 0xAA byte starts a header, which is then read as opcode, count high byte, count low byte.
- R2: For a good packet, `cmd_valid` rises one cycle after the clock edge that takes its last byte. The header-only case counts the count low byte as the last byte. `cmd_opcode` gives the opcode and `cmd_len` gives the count low byte. Payload byte k sits at buffer index k, and `rd_data` shows index `rd_addr` one cycle after the address is applied.
- R3: The required payload counts are:
  - 0 bytes: 0x10, 0x40, 0x70, 0x71 and 0x80.
  - 1 byte: 0x21, 0x45 and 0x46.
  - 2 bytes: 0x16 and 0x20.
  - 10 bytes: 0x41.
  - At least 3 bytes: 0x14.
- R4: A count high byte other than zero, or a count low byte above 59 (the whole packet must stay under 64 bytes), raises `rej_pulse`. The pulse comes one cycle after the count low byte, with `resp_code` = 0x02, and the block returns to hunting.
- R5: A known opcode whose count breaks its R3 rule has its declared payload consumed without storing it. One cycle after the last declared byte, `rej_pulse` rises with `resp_code` = 0x02.
- R6: An opcode outside the R3 set has its declared payload consumed. One cycle after the last byte, `nimp_pulse` rises with `resp_code` = 0xFF, and no command strobe is raised.
- R7: A good 0x80 packet is presented with `cmd_no_ack` = 1. Every other accepted opcode is presented with `cmd_no_ack` = 0.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the opcode, count, `cmd_no_ack` and buffer contents stay stable. Incoming bytes are dropped without any pulse. `cmd_valid` falls one cycle after `cmd_ready` is seen, and hunting resumes.
- R9: Inside a packet, a run of more than `gap_limit` consecutive cycles without a byte drops the partial packet silently and resumes hunting. A run of exactly `gap_limit` is tolerated. A `gap_limit` of zero turns the limit off.
- R10: After reset, `cmd_valid`, `cmd_no_ack`, `rej_pulse` and `nimp_pulse` are low, and the block is hunting.
- R11: `rej_pulse` and `nimp_pulse` last one cycle each and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| gap_limit | input | GAP_W | Maximum idle cycles between bytes of a packet; 0 disables |
| cmd_ready | input | 1 | Executing logic has taken the pending command |
| rd_addr | input | LEN_W | Payload buffer read index |
| cmd_valid | output | 1 | A validated command is pending |
| cmd_opcode | output | 8 | Opcode of the pending command |
| cmd_len | output | LEN_W | Payload byte count of the pending command |
| cmd_no_ack | output | 1 | Pending command must not be acknowledged |
| rd_data | output | 8 | Buffer byte at rd_addr, one cycle late |
| rej_pulse | output | 1 | One-cycle negative-acknowledge request |
| nimp_pulse | output | 1 | One-cycle not-implemented request |
| resp_code | output | 8 | Response code for the latest pulse (0x02 or 0xFF) |

## Verification
The hardest condition to reach from the ports is the idle-gap boundary. A packet must stall in the middle for exactly `gap_limit` cycles and then for one cycle more. The bench sets a small limit and feeds the same packet twice with the pause placed between header bytes. The first pass must be accepted and the second must vanish without any pulse. A second condition that is hard to reach is a complete packet arriving while a command is still pending. The bench holds `cmd_ready` low through such a packet and then checks that the held opcode and buffer byte did not change.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;

  localparam logic [7:0] SYNC_BYTE = 8'hAA;
  localparam logic [7:0] RESP_NACK = 8'h02;
  localparam logic [7:0] RESP_NIMP = 8'hFF;
  localparam logic [7:0] OP_BOOT   = 8'h80;

  typedef enum logic [2:0] {
    ST_HUNT, ST_OPC, ST_LHI, ST_LLO, ST_PAY, ST_SKIP, ST_PEND
  } rx_state_t;

  typedef struct packed {
    logic       known;
    logic       at_least;
    logic [7:0] need;
  } len_rule_t;

  function automatic len_rule_t rule_for(input logic [7:0] op);
    len_rule_t r;
    r = '{known: 1'b1, at_least: 1'b0, need: 8'd0};
    case (op)
      8'h10, 8'h40, 8'h70, 8'h71, 8'h80: r.need = 8'd0;
      8'h21, 8'h45, 8'h46:               r.need = 8'd1;
      8'h16, 8'h20:                      r.need = 8'd2;
      8'h41:                             r.need = 8'd10;
      8'h14: begin
        r.need     = 8'd3;
        r.at_least = 1'b1;
      end
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic len_fits(input len_rule_t r, input logic [7:0] n);
    return r.known && (r.at_least ? (n >= r.need) : (n == r.need));
  endfunction

endpackage

// File: rtl/cmd_len_check.sv
module cmd_len_check
  import cmd_pkt_pkg::*;
#(
  parameter int MAX_PAY = 59
) (
  input  logic [7:0] op,
  input  logic [7:0] len_hi,
  input  logic [7:0] len_lo,
  output logic       hdr_bad,
  output logic       known,
  output logic       fits
);
  len_rule_t rule;

  always_comb begin
    rule    = rule_for(op);
    hdr_bad = (len_hi != 8'd0) || (int'(len_lo) > MAX_PAY);
    known   = rule.known;
    fits    = len_fits(rule, len_lo);
  end
endmodule

// File: rtl/cmd_pay_buf.sv
module cmd_pay_buf #(
  parameter int DW = 8,
  parameter int AW = 6,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmd_gap_timer.sv
module cmd_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             kick,
  input  logic [GAP_W-1:0] limit,
  output logic             expired
);
  logic [GAP_W-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || kick) idle_cnt <= '0;
    else if (idle_cnt != limit) idle_cnt <= idle_cnt + GAP_W'(1);
  end

  assign expired = arm && (limit != '0) && (idle_cnt == limit);
endmodule

// File: rtl/cmd_pkt_rx.sv
module cmd_pkt_rx
  import cmd_pkt_pkg::*;
#(
  parameter int MAX_PKT   = 64,
  parameter int HDR_BYTES = 4,
  parameter int GAP_W     = 16,
  localparam int MAX_PAY  = MAX_PKT - HDR_BYTES - 1,
  localparam int LEN_W    = $clog2(MAX_PAY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic [GAP_W-1:0] gap_limit,
  input  logic             cmd_ready,
  input  logic [LEN_W-1:0] rd_addr,
  output logic             cmd_valid,
  output logic [7:0]       cmd_opcode,
  output logic [LEN_W-1:0] cmd_len,
  output logic             cmd_no_ack,
  output logic [7:0]       rd_data,
  output logic             rej_pulse,
  output logic             nimp_pulse,
  output logic [7:0]       resp_code
);
  rx_state_t        st;
  logic [7:0]       op_r, hi_r;
  logic [LEN_W-1:0] lo_r, cnt;
  logic             skip_nimp;
  logic             hdr_bad, known, fits;
  logic             expired, arm, buf_we;

  cmd_len_check #(.MAX_PAY(MAX_PAY)) u_chk (
    .op(op_r), .len_hi(hi_r), .len_lo(rx_data),
    .hdr_bad(hdr_bad), .known(known), .fits(fits)
  );

  assign arm    = (st == ST_OPC) || (st == ST_LHI) || (st == ST_LLO) ||
                  (st == ST_PAY) || (st == ST_SKIP);
  assign buf_we = (st == ST_PAY) && rx_valid;

  cmd_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .arm(arm), .kick(rx_valid),
    .limit(gap_limit), .expired(expired)
  );

  cmd_pay_buf #(.DW(8), .AW(LEN_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(cnt), .wdata(rx_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HUNT;
      op_r       <= '0;
      hi_r       <= '0;
      lo_r       <= '0;
      cnt        <= '0;
      skip_nimp  <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_no_ack <= 1'b0;
      rej_pulse  <= 1'b0;
      nimp_pulse <= 1'b0;
      resp_code  <= RESP_NACK;
    end else begin
      rej_pulse  <= 1'b0;
      nimp_pulse <= 1'b0;
      case (st)
        ST_HUNT: if (rx_valid && rx_data == SYNC_BYTE) st <= ST_OPC;
        ST_OPC: begin
          if (rx_valid) begin
            op_r <= rx_data;
            st   <= ST_LHI;
          end else if (expired) st <= ST_HUNT;
        end
        ST_LHI: begin
          if (rx_valid) begin
            hi_r <= rx_data;
            st   <= ST_LLO;
          end else if (expired) st <= ST_HUNT;
        end
        ST_LLO: begin
          if (rx_valid) begin
            lo_r      <= rx_data[LEN_W-1:0];
            cnt       <= '0;
            skip_nimp <= !known;
            if (hdr_bad) begin
              rej_pulse <= 1'b1;
              resp_code <= RESP_NACK;
              st        <= ST_HUNT;
            end else if (fits) begin
              if (rx_data == 8'd0) begin
                cmd_valid  <= 1'b1;
                cmd_no_ack <= (op_r == OP_BOOT);
                st         <= ST_PEND;
              end else st <= ST_PAY;
            end else if (rx_data == 8'd0) begin
              rej_pulse  <= known;
              nimp_pulse <= !known;
              resp_code  <= known ? RESP_NACK : RESP_NIMP;
              st         <= ST_HUNT;
            end else st <= ST_SKIP;
          end else if (expired) st <= ST_HUNT;
        end
        ST_PAY: begin
          if (rx_valid) begin
            cnt <= cnt + LEN_W'(1);
            if (cnt == lo_r - LEN_W'(1)) begin
              cmd_valid  <= 1'b1;
              cmd_no_ack <= (op_r == OP_BOOT);
              st         <= ST_PEND;
            end
          end else if (expired) st <= ST_HUNT;
        end
        ST_SKIP: begin
          if (rx_valid) begin
            cnt <= cnt + LEN_W'(1);
            if (cnt == lo_r - LEN_W'(1)) begin
              rej_pulse  <= !skip_nimp;
              nimp_pulse <= skip_nimp;
              resp_code  <= skip_nimp ? RESP_NIMP : RESP_NACK;
              st         <= ST_HUNT;
            end
          end else if (expired) st <= ST_HUNT;
        end
        ST_PEND: begin
          if (cmd_ready) begin
            cmd_valid  <= 1'b0;
            cmd_no_ack <= 1'b0;
            st         <= ST_HUNT;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  assign cmd_opcode = op_r;
  assign cmd_len    = lo_r;

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) &&
      $stable(cmd_len) && $stable(cmd_no_ack)); // R8
  AST_RELEASE_ON_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_valid); // R8
  AST_NO_PULSE_PENDING: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !rej_pulse && !nimp_pulse); // R8
  AST_STROBE_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> len_fits(rule_for(cmd_opcode), 8'(cmd_len))); // R3
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rej_pulse && nimp_pulse)); // R11
  AST_REJ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rej_pulse |=> !rej_pulse); // R11
  AST_NIMP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    nimp_pulse |=> !nimp_pulse); // R11
  AST_BOOT_SILENT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_no_ack == (cmd_opcode == OP_BOOT))); // R7
endmodule

// File: tb/sim_cmd_pkt_rx.sv
module sim_cmd_pkt_rx;
  localparam int LEN_W = 6;
  localparam int GAP_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       rx_data = '0;
  logic             rx_valid = 1'b0;
  logic [GAP_W-1:0] gap_limit = 16'd8;
  logic             cmd_ready = 1'b0;
  logic [LEN_W-1:0] rd_addr = '0;
  logic             cmd_valid, cmd_no_ack, rej_pulse, nimp_pulse;
  logic [7:0]       cmd_opcode, rd_data, resp_code;
  logic [LEN_W-1:0] cmd_len;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cmd_pkt_rx u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .gap_limit(gap_limit), .cmd_ready(cmd_ready), .rd_addr(rd_addr),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_len(cmd_len),
    .cmd_no_ack(cmd_no_ack), .rd_data(rd_data), .rej_pulse(rej_pulse),
    .nimp_pulse(nimp_pulse), .resp_code(resp_code)
  );

  // {outcome, opcode, count high, count low}; outcome 0=command 1=reject 2=not implemented
  localparam logic [31:0] VEC [14] = '{
    32'h00_10_00_00, 32'h00_45_00_01, 32'h00_14_00_03, 32'h00_14_00_07,
    32'h01_14_00_02, 32'h01_16_00_03, 32'h00_41_00_0A, 32'h02_33_00_00,
    32'h02_99_00_02, 32'h01_20_01_02, 32'h01_14_00_3C, 32'h00_14_00_3B,
    32'h00_80_00_00, 32'h00_21_00_01
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_cmd();
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(cmd_valid == 1'b0, "R8 release", int'(cmd_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R10 reset state
    chk(!cmd_valid && !cmd_no_ack && !rej_pulse && !nimp_pulse, "R10 reset",
        {cmd_valid, cmd_no_ack, rej_pulse, nimp_pulse}, 0);

    for (int k = 0; k < 14; k++) begin
      logic [7:0] op, hi, lo, oc;
      bit hdr_only;
      {oc, op, hi, lo} = VEC[k];
      hdr_only = (hi != 8'd0) || (lo > 8'd59);
      send(8'h55);                       // R1 noise while hunting
      send(8'hAA); send(op); send(hi); send(lo);
      if (!hdr_only)
        for (int i = 0; i < int'(lo); i++) send(8'h30 + 8'(i));
      if (oc == 8'd0) begin
        chk(cmd_valid, "R2 strobe", int'(cmd_valid), 1);
        chk(cmd_opcode == op, "R3 opcode", cmd_opcode, op);
        chk(8'(cmd_len) == lo, "R2 length", cmd_len, lo);
        chk(cmd_no_ack == (op == 8'h80), "R7 no_ack", int'(cmd_no_ack), int'(op == 8'h80));
        for (int i = 0; i < int'(lo); i++) begin
          rd_addr = LEN_W'(i);
          @(negedge clk);
          chk(rd_data == 8'h30 + 8'(i), "R2 payload", rd_data, 8'h30 + i);
        end
        release_cmd();
      end else if (oc == 8'd1) begin
        chk(rej_pulse && !nimp_pulse && resp_code == 8'h02 && !cmd_valid,
            hdr_only ? "R4 header reject" : "R5 count reject",
            {rej_pulse, nimp_pulse, resp_code}, 10'h202);
        @(negedge clk);
        chk(!rej_pulse, "R11 single rej", int'(rej_pulse), 0);
      end else begin
        chk(nimp_pulse && !rej_pulse && resp_code == 8'hFF && !cmd_valid,
            "R6 not implemented", {rej_pulse, nimp_pulse, resp_code}, 10'h1FF);
        @(negedge clk);
        chk(!nimp_pulse, "R11 single nimp", int'(nimp_pulse), 0);
      end
    end

    // R1: several non-sync bytes, then a zero-payload packet
    send(8'h00); send(8'hAB); send(8'h55);
    chk(!cmd_valid && !rej_pulse && !nimp_pulse, "R1 ignore", int'(cmd_valid), 0);
    send(8'hAA); send(8'h70); send(8'h00); send(8'h00);
    chk(cmd_valid && cmd_opcode == 8'h70, "R1 sync", cmd_opcode, 8'h70);
    release_cmd();

    // R8: a full packet arriving while pending is dropped
    send(8'hAA); send(8'h46); send(8'h00); send(8'h01); send(8'h11);
    chk(cmd_valid && cmd_opcode == 8'h46, "R8 first", cmd_opcode, 8'h46);
    send(8'hAA); send(8'h45); send(8'h00); send(8'h01); send(8'h22);
    chk(!rej_pulse && !nimp_pulse, "R8 no pulse", int'(rej_pulse), 0);
    idle(3);
    chk(cmd_valid && cmd_opcode == 8'h46 && cmd_len == 6'd1, "R8 hold", cmd_opcode, 8'h46);
    rd_addr = '0;
    @(negedge clk);
    chk(rd_data == 8'h11, "R8 buffer", rd_data, 8'h11);
    release_cmd();
    idle(3);
    chk(!cmd_valid, "R8 dropped", int'(cmd_valid), 0);

    // R9: gap of exactly the limit is tolerated
    gap_limit = 16'd8;
    send(8'hAA); send(8'h45); idle(8); send(8'h00); idle(8); send(8'h01); idle(8); send(8'h80);
    chk(cmd_valid && cmd_opcode == 8'h45, "R9 at limit", int'(cmd_valid), 1);
    release_cmd();
    // R9: one more idle cycle drops the packet silently
    send(8'hAA); send(8'h45); idle(9); send(8'h00);
    chk(!rej_pulse && !nimp_pulse, "R9 silent drop", int'(rej_pulse), 0);
    send(8'h01); send(8'h80);
    chk(!cmd_valid && !rej_pulse && !nimp_pulse, "R9 over limit", int'(cmd_valid), 0);
    send(8'hAA); send(8'h71); send(8'h00); send(8'h00);
    chk(cmd_valid && cmd_opcode == 8'h71, "R9 recovery", cmd_opcode, 8'h71);
    release_cmd();
    // R9: limit zero disables the timeout
    gap_limit = 16'd0;
    send(8'hAA); send(8'h10); idle(50); send(8'h00); idle(50); send(8'h00);
    chk(cmd_valid && cmd_opcode == 8'h10, "R9 disabled", int'(cmd_valid), 1);
    release_cmd();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule